// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel port peripheral. It has three 8-bit ports, called A, B and C, and one control register. A host reaches it through an active-low chip select, active-low read and write strobes, a 2-bit register address and an 8-bit data path. Only the basic mode is built. Outputs are held in latches, and inputs pass through to the read data without latching. There is no handshake and no interrupt.

Every port pin has its own output value and its own output enable, so tri-state pads can sit outside the block. Port A and port B each take one direction for the whole port. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. The control address takes two kinds of word, and bit 7 picks which one applies. A mode word sets the four directions. A single-bit command sets or clears one port C latch bit.

A write takes effect on the rising clock edge where chip select and write strobe are both low. Read data is combinational while chip select and read strobe are low.

Top module: `ppi_port`

## Requirements
- R1: The address selects the register: 0 is port A, 1 is port B, 2 is port C and 3 is control. A write to address 0, 1 or 2 loads that port's output latch from `din` at the clock edge.
- R2: While `cs_n` is high, no latch or control state changes and `dout_en` stays low. `dout_en` is high only when `cs_n` and `rd_n` are low and `wr_n` is high. `dout` is 0 whenever `dout_en` is low.
- R3: A control write with bit 7 = 1 sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 3 the upper nibble of port C, bit 1 port B and bit 0 the lower nibble of port C. An output drives `*_oe` high. The word 0x80 makes every pin an output. The word 0x90 makes port A an input and ports B and C outputs.
- R4: A control write with bit 7 = 0 is a single-bit command. Bits 3..1 give the index of a port C bit, and bit 0 is its new latch value. Bits 6..4 are ignored, and the other port C bits keep their value.
- R5: A single-bit command updates the port C latch even while that nibble is an input. The new value shows on `pc_out` once the nibble is switched to output.
- R6: After reset, all latches are 0 and all 24 `*_oe` are 0. A read of any port then returns its input pins.
- R7: A read of a port returns the latch for each pin that is an output and the input pin for each pin that is an input. Port C makes this choice for each nibble.
- R8: A read of the control address returns 0x00.
- R9: Mode bits 6..5 and 2 are accepted for any value, including values that ask for the handshake modes. The block then behaves as the basic mode with the directions from R3, and the mode bits change only on a control write with bit 7 = 1.
- R10: A mode word leaves the three output latches unchanged. A port write to a port that is set as input still loads the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| dout_en | output | 1 | High while the read data is driven |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
Random sequences mix port writes, mode words with every direction pattern, single-bit commands with random values in the ignored bits, and reads, while the pin inputs change every operation. These sequences separate latch data from pin data on reads, and they separate the two port C nibbles from each other. Directed cases cover 0x80 and 0x90, writes with chip select high, and single-bit commands that hit a port C nibble set as input before it is turned to output. Mode words that ask for the handshake modes show that only the direction bits matter.

// File: rtl/ppi_port.sv
module ppi_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  localparam logic [1:0] ADR_A   = 2'd0;
  localparam logic [1:0] ADR_B   = 2'd1;
  localparam logic [1:0] ADR_C   = 2'd2;
  localparam logic [1:0] ADR_CTL = 2'd3;
  localparam logic [6:0] CFG_RST = 7'b001_1011;

  logic [7:0] pa_q, pb_q, pc_q;
  logic [6:0] cfg_q;
  logic       wr_en, ctl_wr;
  logic [7:0] a_rd, b_rd, c_rd, rd_mux;

  assign wr_en   = !cs_n && !wr_n;
  assign ctl_wr  = wr_en && (addr == ADR_CTL);
  assign dout_en = !cs_n && !rd_n && wr_n;

  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign pa_oe  = {8{~cfg_q[4]}};
  assign pb_oe  = {8{~cfg_q[1]}};
  assign pc_oe  = {{4{~cfg_q[3]}}, {4{~cfg_q[0]}}};

  assign a_rd = (pa_in & ~pa_oe) | (pa_q & pa_oe);
  assign b_rd = (pb_in & ~pb_oe) | (pb_q & pb_oe);
  assign c_rd = (pc_in & ~pc_oe) | (pc_q & pc_oe);

  always_comb begin
    case (addr)
      ADR_A:   rd_mux = a_rd;
      ADR_B:   rd_mux = b_rd;
      ADR_C:   rd_mux = c_rd;
      default: rd_mux = 8'h00;
    endcase
  end

  assign dout = dout_en ? rd_mux : 8'h00;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pa_q  <= 8'h00;
      pb_q  <= 8'h00;
      pc_q  <= 8'h00;
      cfg_q <= CFG_RST;
    end else if (wr_en) begin
      case (addr)
        ADR_A: pa_q <= din;
        ADR_B: pb_q <= din;
        ADR_C: pc_q <= din;
        default: begin
          if (din[7]) cfg_q <= din[6:0];
          else        pc_q[din[3:1]] <= din[0];
        end
      endcase
    end
  end

  // R4
  bit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !din[7]) |=> pc_q[$past(din[3:1])] == $past(din[0]));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(pa_q) && $stable(pb_q) && $stable(pc_q) && $stable(cfg_q));

  // R3
  dir_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && din[7]) |=> (pa_oe == {8{~$past(din[4])}}) && (pb_oe == {8{~$past(din[1])}})
      && (pc_oe[7:4] == {4{~$past(din[3])}}) && (pc_oe[3:0] == {4{~$past(din[0])}}));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && din[7]) |=> $stable(cfg_q[6:5]) && $stable(cfg_q[2]));

  // R10
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && din[7]) |=> $stable(pa_q) && $stable(pb_q) && $stable(pc_q));

  // R8
  ctl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_en && addr == ADR_CTL) |-> dout == 8'h00);

  // R6
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(wr_en)) |-> (pa_oe == 8'h00) && (pb_oe == 8'h00) && (pc_oe == 8'h00)
      && (pa_q == 8'h00) && (pb_q == 8'h00) && (pc_q == 8'h00));

endmodule

// File: tb/ppi_port_tb_top.sv
module ppi_port_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       dout_en;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_a = 0, m_b = 0, m_c = 0;
  logic [3:0] m_dir = 4'hF;  // {A, C upper, B, C lower}, 1 = input
  bit done = 0;

  always #10 clk = ~clk;

  ppi_port dut_i (.clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  function automatic logic [7:0] oe_of(input int p);
    case (p)
      0: return {8{~m_dir[3]}};
      1: return {8{~m_dir[1]}};
      default: return {{4{~m_dir[2]}}, {4{~m_dir[0]}}};
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return (pa_in & ~oe_of(0)) | (m_a & oe_of(0));
      2'd1: return (pb_in & ~oe_of(1)) | (m_b & oe_of(1));
      2'd2: return (pc_in & ~oe_of(2)) | (m_c & oe_of(2));
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    check(req, {pa_out, pb_out, pc_out}, {m_a, m_b, m_c});
    check(req, {pa_oe, pb_oe, pc_oe}, {oe_of(0), oe_of(1), oe_of(2)});
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: if (d[7]) m_dir = {d[4], d[3], d[1], d[0]};
               else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; din = d; cs_n = 0; wr_n = 0;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    model_wr(a, d);
    check_pins(req);
  endtask

  task automatic bus_rd(input logic [1:0] a, input string req);
    @(negedge clk);
    addr = a; cs_n = 0; rd_n = 0;
    #2;
    check(req, {dout_en, dout}, {1'b1, exp_rd(a)});
    cs_n = 1; rd_n = 1;
    #1;
    check("R2", {dout_en, dout}, 9'h000);
  endtask

  task automatic rand_pins();
    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R6 reset state
    check_pins("R6");
    pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h96;
    bus_rd(2'd0, "R6"); bus_rd(2'd1, "R6"); bus_rd(2'd2, "R6");
    // R8 control read
    bus_rd(2'd3, "R8");
    // R3 all outputs
    bus_wr(2'd3, 8'h80, "R3");
    check("R3", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
    // R1 port writes and reads back
    bus_wr(2'd0, 8'h55, "R1"); bus_wr(2'd1, 8'hAA, "R1"); bus_wr(2'd2, 8'hC3, "R1");
    bus_rd(2'd0, "R1"); bus_rd(2'd1, "R1"); bus_rd(2'd2, "R1");
    // R3 0x90
    bus_wr(2'd3, 8'h90, "R3");
    check("R3", {pa_oe, pb_oe, pc_oe}, 24'h00FFFF);
    bus_rd(2'd0, "R7");
    // R10 mode word keeps latches
    check("R10", pa_out, 8'h55);
    // R2 chip select high blocks writes
    @(negedge clk);
    addr = 2'd1; din = 8'h0F; wr_n = 0; cs_n = 1;
    @(negedge clk);
    wr_n = 1;
    check("R2", pb_out, 8'hAA);
    check("R2", dout_en, 1'b0);
    // R4 single-bit commands, ignored bits set
    bus_wr(2'd3, 8'h70 | 8'h07, "R4");  // bit 3 set
    check("R4", pc_out, 8'hCB);
    bus_wr(2'd3, 8'h7E, "R4");  // bit 7 clear
    check("R4", pc_out, 8'h4B);
    // R5 command into an input nibble
    bus_wr(2'd3, 8'h89, "R5");  // C both nibbles input
    bus_wr(2'd3, 8'h0D, "R5");  // set bit 6
    bus_wr(2'd3, 8'h00, "R5");  // clear bit 0
    check("R5", pc_oe, 8'h00);
    bus_wr(2'd3, 8'h80, "R5");
    check("R5", pc_out, 8'h4A);
    // R9 handshake-mode requests act as basic mode
    bus_wr(2'd3, 8'hE6, "R9");
    check("R9", {pa_oe, pb_oe, pc_oe}, 24'hFF00FF);
    bus_rd(2'd1, "R9");
    bus_wr(2'd3, 8'hBD, "R9");
    bus_rd(2'd2, "R9");
    // R10 port write while input loads latch
    bus_wr(2'd3, 8'h9B, "R10");
    bus_wr(2'd0, 8'h3E, "R10");
    bus_wr(2'd3, 8'h80, "R10");
    check("R10", pa_out, 8'h3E);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [1:0] a;
      rand_pins();
      op = $urandom_range(0, 9);
      a = 2'($urandom);
      if (op < 4) bus_rd(a, "R7");
      else if (op < 6) bus_wr(2'd3, {1'b1, 7'($urandom)}, "R3");
      else if (op < 8) bus_wr(2'd3, {1'b0, 7'($urandom)}, "R4");
      else bus_wr(a == 2'd3 ? 2'd0 : a, 8'($urandom), "R1");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule